// File: doc/BRIEF.md
# Low-Power Mode Controller

This block holds the power-control register of a small microcontroller core and turns its two lowest bits into clock enables. Software writes the register through a simple CPU-side port. Setting bit 0 alone requests idle: the CPU clock enable drops, and the peripheral clock enable stays high so that timers and interrupt logic keep running. Setting bit 1 requests power-down: both clock enables drop. In either low-power mode a RAM-retain flag is raised so that the memory array holds its contents while clocks are stopped.

Exit rules differ by depth. Idle ends when a pending enabled interrupt is seen at a clock edge. Hardware clears bit 0 by itself, so the CPU resumes after the instruction that entered idle. Power-down ignores interrupts, and only a reset ends it. The reset is asynchronous and active low. Its assertion clears the register at once, and its release passes through a short synchronizer before the register is allowed to load again.

Top module: `lpm_power_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the register reads 00h, cpu_clk_en and periph_clk_en are 1, and ram_retain is 0.
- R2: After a write of a value whose two low bits are 01, from the clock edge that takes the write onward: cpu_clk_en is 0, periph_clk_en is 1 and ram_retain is 1, and this holds until a wake event.
- R3: After a write of a value with bit 1 set (bit 0 either way), cpu_clk_en and periph_clk_en are both 0 and ram_retain is 1. Bit 1 takes precedence over bit 0, and periph_clk_en never falls while cpu_clk_en is high.
- R4: In idle, an interrupt pending at a clock edge with no write clears bit 0 at that edge, leaves bits 7..1 unchanged, and cpu_clk_en returns to 1 with ram_retain back to 0.
- R5: In power-down, a pending interrupt is ignored: the register value and both clock enables do not change.
- R6: Asserting reset in any mode clears the register and restores both clock enables at once, without waiting for a clock edge.
- R7: Bits 7..2 are stored and read back unchanged, and they do not affect the clock enables.
- R8: reg_rdata shows the current register contents without a read strobe. A write becomes visible right after the clock edge that takes it.
- R9: When a write and a pending interrupt occur at the same edge, the written value is stored unchanged.
- R10: In normal mode a pending interrupt has no effect on the register or on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-running clock of the controller |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the power-control register |
| reg_wdata | input | 8 | Value to write |
| reg_rdata | output | 8 | Current register contents |
| irq_pending | input | 1 | An enabled interrupt is pending |
| cpu_clk_en | output | 1 | Clock enable for the CPU core |
| periph_clk_en | output | 1 | Clock enable for timers, serial port and interrupt logic |
| ram_retain | output | 1 | RAM must keep its contents with clocks stopped |

## Verification
The mode decode is driven with writes of 00h, 01h, 02h and 03h, and with values whose upper bits are set. These show whether bit 1 overrides bit 0 and whether the upper bits affect the enables. Interrupt pulses are applied in each of the three modes. This separates the idle self-clear from the interrupts that power-down and normal mode must ignore, and a case with the upper bits set confirms that the clear touches only bit 0. A write in the same cycle as an interrupt tests the write priority, and a reset asserted between clock edges in power-down shows that the exit happens without waiting for an edge.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  localparam int IDLE_BIT = 0;
  localparam int DOWN_BIT = 1;

  typedef enum logic [1:0] {
    LPM_RUN  = 2'b00,
    LPM_IDLE = 2'b01,
    LPM_DOWN = 2'b10
  } lpm_mode_e;

endpackage

// File: rtl/lpm_rst_sync.sv
module lpm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  generate
    if (STAGES > 1) begin : g_multi
      always_comb chain_d = {chain_q[LAST-1:0], 1'b1};
    end else begin : g_single
      always_comb chain_d = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[LAST];

endmodule

// File: rtl/lpm_ctrl_reg.sv
module lpm_ctrl_reg
  import lpm_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             wake_clr,
  output logic [REG_W-1:0] q
);

  logic [REG_W-1:0] q_nxt;
  logic             q_load;

  // Next-state: software write has priority over the idle self-clear.
  always_comb begin
    q_nxt  = q;
    q_load = 1'b0;
    if (wr_en) begin
      q_nxt  = wdata;
      q_load = 1'b1;
    end else if (wake_clr) begin
      q_nxt[IDLE_BIT] = 1'b0;
      q_load          = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (q_load) q <= q_nxt;
  end

endmodule

// File: rtl/lpm_mode_decode.sv
module lpm_mode_decode
  import lpm_pkg::*;
(
  input  logic [1:0] mode_bits,
  output lpm_mode_e  mode
);

  // Deeper sleep wins when both request bits are set.
  always_comb begin
    if (mode_bits[DOWN_BIT])      mode = LPM_DOWN;
    else if (mode_bits[IDLE_BIT]) mode = LPM_IDLE;
    else                          mode = LPM_RUN;
  end

endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
  import lpm_pkg::*;
(
  input  lpm_mode_e mode,
  input  logic      irq_pending,
  output logic      cpu_en,
  output logic      periph_en,
  output logic      retain,
  output logic      wake_clr
);

  always_comb begin
    cpu_en    = 1'b1;
    periph_en = 1'b1;
    retain    = 1'b0;
    wake_clr  = 1'b0;
    case (mode)
      LPM_IDLE: begin
        cpu_en   = 1'b0;
        retain   = 1'b1;
        wake_clr = irq_pending;
      end
      LPM_DOWN: begin
        cpu_en    = 1'b0;
        periph_en = 1'b0;
        retain    = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/lpm_power_ctrl.sv
module lpm_power_ctrl
  import lpm_pkg::*;
#(
  parameter int REG_W      = 8,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             irq_pending,
  output logic             cpu_clk_en,
  output logic             periph_clk_en,
  output logic             ram_retain
);

  logic             rst_sync_n;
  logic [REG_W-1:0] ctrl_q;
  logic             wake_clr;
  lpm_mode_e        mode;

  lpm_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  lpm_ctrl_reg #(.REG_W(REG_W)) u_ctrl_reg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (reg_wr_en),
    .wdata    (reg_wdata),
    .wake_clr (wake_clr),
    .q        (ctrl_q)
  );

  lpm_mode_decode u_decode (
    .mode_bits (ctrl_q[1:0]),
    .mode      (mode)
  );

  lpm_clk_ctrl u_clk_ctrl (
    .mode        (mode),
    .irq_pending (irq_pending),
    .cpu_en      (cpu_clk_en),
    .periph_en   (periph_clk_en),
    .retain      (ram_retain),
    .wake_clr    (wake_clr)
  );

  assign reg_rdata = ctrl_q;

endmodule

// File: rtl/lpm_power_ctrl_chk.sv
module lpm_power_ctrl_chk #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             reg_wr_en,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic             irq_pending,
  input logic             cpu_clk_en,
  input logic             periph_clk_en,
  input logic             ram_retain
);

  AST_IDLE_ENABLES: assert property (@(posedge clk) disable iff (!rst_ok)
    (reg_rdata[1:0] == 2'b01) |-> (!cpu_clk_en && periph_clk_en && ram_retain)); // R2

  AST_DOWN_ENABLES: assert property (@(posedge clk) disable iff (!rst_ok)
    reg_rdata[1] |-> (!cpu_clk_en && !periph_clk_en && ram_retain)); // R3

  AST_CLK_ORDER: assert property (@(posedge clk) disable iff (!rst_ok)
    !periph_clk_en |-> !cpu_clk_en); // R3

  AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rst_ok)
    ((reg_rdata[1:0] == 2'b01) && irq_pending && !reg_wr_en)
    |=> (cpu_clk_en && !reg_rdata[0])); // R4

  AST_DOWN_DEAF: assert property (@(posedge clk) disable iff (!rst_ok)
    (reg_rdata[1] && !reg_wr_en) |=> $stable(reg_rdata)); // R5

  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_ok)
    reg_wr_en |=> (reg_rdata == $past(reg_wdata))); // R9

  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    ((reg_rdata[1:0] == 2'b00) && !reg_wr_en) |=> $stable(reg_rdata)); // R10

endmodule

bind lpm_power_ctrl lpm_power_ctrl_chk #(.REG_W(REG_W)) u_chk (
  .clk           (clk),
  .rst_ok        (rst_sync_n),
  .reg_wr_en     (reg_wr_en),
  .reg_wdata     (reg_wdata),
  .reg_rdata     (reg_rdata),
  .irq_pending   (irq_pending),
  .cpu_clk_en    (cpu_clk_en),
  .periph_clk_en (periph_clk_en),
  .ram_retain    (ram_retain)
);

// File: tb/lpm_power_ctrl_tb_top.sv
`timescale 1ns/1ps
module lpm_power_ctrl_tb_top;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic       reg_wr_en;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq_pending;
  logic       cpu_clk_en;
  logic       periph_clk_en;
  logic       ram_retain;

  int   n_checks;
  int   n_fails;
  exp_t sb_q[$];
  logic [7:0] model;

  lpm_power_ctrl dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr_en     (reg_wr_en),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .irq_pending   (irq_pending),
    .cpu_clk_en    (cpu_clk_en),
    .periph_clk_en (periph_clk_en),
    .ram_retain    (ram_retain)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Compare outputs against a register value expected by the requirements.
  task automatic compare(input logic [7:0] v, input string tag);
    logic e_cpu, e_per, e_ret;
    e_cpu = (v[1:0] == 2'b00);
    e_per = !v[1];
    e_ret = (v[1:0] != 2'b00);
    n_checks++;
    if (reg_rdata !== v || cpu_clk_en !== e_cpu ||
        periph_clk_en !== e_per || ram_retain !== e_ret) begin
      n_fails++;
      $display("FAIL %s: rdata=%h cpu=%b per=%b ret=%b, expected rdata=%h cpu=%b per=%b ret=%b",
               tag, reg_rdata, cpu_clk_en, periph_clk_en, ram_retain,
               v, e_cpu, e_per, e_ret);
    end
  endtask

  // Monitor: pops expected items once outputs have settled after an edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        compare(it.val, it.tag);
      end
    end
  end

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic step(input logic wr, input logic [7:0] d, input logic irq,
                      input string tag);
    exp_t it;
    @(negedge clk);
    reg_wr_en   = wr;
    reg_wdata   = d;
    irq_pending = irq;
    if (wr)                                  model = d;
    else if (model[1:0] == 2'b01 && irq)     model[0] = 1'b0;
    @(posedge clk);
    #1;
    it.val = model;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Reset asserted between edges; outputs must change without a clock edge.
  task automatic async_reset(input string tag);
    @(negedge clk);
    reg_wr_en   = 1'b0;
    irq_pending = 1'b0;
    #2;
    rst_n = 1'b0;
    #1;
    model = 8'h00;
    compare(8'h00, tag);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare(8'h00, tag);
  endtask

  initial begin
    n_checks    = 0;
    n_fails     = 0;
    model       = 8'h00;
    rst_n       = 1'b0;
    reg_wr_en   = 1'b0;
    reg_wdata   = 8'h00;
    irq_pending = 1'b0;
    repeat (3) @(negedge clk);
    compare(8'h00, "R1 during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare(8'h00, "R1 after reset");

    step(1'b0, 8'h00, 1'b1, "R10 irq in run mode");
    step(1'b0, 8'h00, 1'b0, "R10 settle");
    step(1'b1, 8'hA4, 1'b0, "R7 upper bits stored, run mode");
    step(1'b0, 8'h00, 1'b0, "R8 readback holds");
    step(1'b1, 8'h01, 1'b0, "R2 enter idle");
    step(1'b0, 8'h00, 1'b0, "R2 idle held");
    step(1'b0, 8'h00, 1'b0, "R2 idle held again");
    step(1'b0, 8'h00, 1'b1, "R4 wake from idle");
    step(1'b0, 8'h00, 1'b0, "R4 after wake");
    step(1'b1, 8'hC1, 1'b0, "R7 idle with upper bits");
    step(1'b0, 8'h00, 1'b1, "R4 wake keeps upper bits");
    step(1'b1, 8'h02, 1'b0, "R3 enter power-down");
    step(1'b0, 8'h00, 1'b1, "R5 irq ignored in power-down");
    step(1'b0, 8'h00, 1'b1, "R5 irq ignored again");
    step(1'b0, 8'h00, 1'b0, "R5 still down");
    step(1'b1, 8'h03, 1'b0, "R3 both bits set");
    step(1'b0, 8'h00, 1'b1, "R5 irq with both bits");
    async_reset("R6 reset exits power-down");
    step(1'b1, 8'h01, 1'b0, "R2 idle again");
    step(1'b1, 8'h05, 1'b1, "R9 write beats irq");
    step(1'b0, 8'h00, 1'b1, "R4 wake after write");
    step(1'b1, 8'hFD, 1'b0, "R7 upper bits in idle");
    async_reset("R6 reset exits idle");
    step(1'b0, 8'h00, 1'b0, "R1 idle after reset");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule